// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block collects up to 32 interrupt source lines into one processor interrupt request. A rising edge on a source line sets a sticky pending bit. That bit stays set until software writes a one to it in the masked status register. Each source also has an enable bit. Software never writes the enable bits as a word. It sets them through one write-one-to-set register and clears them through a separate write-one-to-clear register, so updating one source never needs a read-modify-write that could race with another.

Software reaches the block over a small bus with word addresses, a read strobe and a write strobe. Word 0 returns the pending bits gated by their enables, and a write there acknowledges. Word 1 returns the raw pending bits, whatever their enables. Word 2 is the enable-set port and word 3 the enable-clear port. The block drives a registered interrupt request. It also reports the index of the lowest-numbered enabled pending source, with a valid flag, so a handler can dispatch without scanning the status word. When nothing is pending, the index output carries the out-of-range code 32 and the valid flag is low.

The default source assignment starts with an external fast input at index 0. Then come battery low at 1, watchdog expiry at 2, media change at 3, the sound codec at 4 and a configurable input at 5. Because the lowest index wins, this order is also the service priority.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset, all enable bits and all pending bits are zero. `irq_o` is low, `irq_id_vld_o` is low and `irq_id_o` equals 32.
- R2: A 0-to-1 transition on `src_i[n]` sets pending bit n one clock later. The bit stays set after the line falls until it is acknowledged. A line that stays high does not set the bit again after an acknowledge.
- R3: A write to word address 2 sets the enable of every source whose data bit is 1. Enables whose data bit is 0 keep their value.
- R4: A write to word address 3 clears the enable of every source whose data bit is 1. Writing all ones disables every source.
- R5: A write to word address 0 clears the pending bit of every source whose data bit is 1 and leaves the others. If a rising edge on a source arrives in the same cycle as its acknowledge, the bit stays set.
- R6: A read of word address 1 returns the pending bits regardless of enable. A read of word address 0 returns the pending bits ANDed with the enables.
- R7: `irq_o` equals the OR of the masked status bits, delayed by exactly one clock.
- R8: `irq_id_o` gives the lowest bit index set in the masked status, and `irq_id_vld_o` is high. With no masked bit set, the index is 32 and the valid flag is low.
- R9: Reads of word addresses 2 and 3 return zero. A write to word address 1 changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| src_i | input | 32 | Interrupt source lines, bit n is source n |
| bus_addr | input | 2 | Word address: 0 masked status/ack, 1 raw status, 2 enable set, 3 enable clear |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is zero while low |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| irq_o | output | 1 | Registered interrupt request to the processor |
| irq_id_o | output | 6 | Index of the lowest enabled pending source, 32 when none |
| irq_id_vld_o | output | 1 | High when `irq_id_o` names a real source |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a fresh rising edge on the same source. The bench builds it by driving the write strobe, the acknowledge mask and the source edge at one falling clock edge. It then reads raw status to confirm that the bit survived. A second hard case is a source that stays high across an acknowledge. The bench holds the line high, acknowledges, and reads raw status to show that no new edge was seen. The priority search is driven with sources at both ends of the vector, 0 and 31. It is then stepped through acknowledges until it reports the none code.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASKED = 2'd0,
        REG_RAW    = 2'd1,
        REG_EN_SET = 2'd2,
        REG_EN_CLR = 2'd3
    } irq_reg_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] rise;

    assign rise = src_i & ~src_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_i;
            pend_q <= (pend_q & ~ack_i) | rise;
        end
    end

    assign pend_o = pend_q;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(rise)) == $past(rise))); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~ack_i)) == $past(pend_q & ~ack_i))); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_i) |=> ((pend_q & $past(ack_i & ~rise)) == '0)); // R5
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] en_o
);
    logic [NSRC-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_i) & ~clr_i;
    end

    assign en_o = en_q;

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_i) && !(|clr_i)) |=> ((en_q & $past(set_i)) == $past(set_i))); // R3
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(~set_i & ~clr_i)) == $past(en_q & ~set_i & ~clr_i))); // R3
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((en_q & $past(clr_i)) == '0)); // R4
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
    parameter int NSRC = 32,
    localparam int ID_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0] req_i,
    output logic [ID_W-1:0] id_o,
    output logic            vld_o
);
    always_comb begin
        id_o = ID_W'(NSRC);
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) id_o = ID_W'(i);
        end
        vld_o = |req_i;
    end
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
    import irq_setclr_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int ID_W = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic [ID_W-1:0]   irq_id_o,
    output logic              irq_id_vld_o
);
    irq_reg_e        sel;
    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] ack_mask;
    logic [NSRC-1:0] set_mask;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] masked;
    logic            irq_q;

    assign sel   = irq_reg_e'(bus_addr);
    assign wmask = bus_wdata[NSRC-1:0];

    always_comb begin
        ack_mask = '0;
        set_mask = '0;
        clr_mask = '0;
        if (bus_wr) begin
            unique case (sel)
                REG_MASKED: ack_mask = wmask;
                REG_RAW:    ;
                REG_EN_SET: set_mask = wmask;
                REG_EN_CLR: clr_mask = wmask;
            endcase
        end
    end

    irq_edge_latch #(.NSRC(NSRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .ack_i  (ack_mask),
        .pend_o (pend)
    );

    irq_enable_bank #(.NSRC(NSRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_mask),
        .clr_i (clr_mask),
        .en_o  (en)
    );

    assign masked = pend & en;

    irq_lowest_enc #(.NSRC(NSRC)) u_enc (
        .req_i (masked),
        .id_o  (irq_id_o),
        .vld_o (irq_id_vld_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                REG_MASKED: bus_rdata[NSRC-1:0] = masked;
                REG_RAW:    bus_rdata[NSRC-1:0] = pend;
                REG_EN_SET: bus_rdata = '0;
                REG_EN_CLR: bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked;
    end

    assign irq_o = irq_q;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked) |=> irq_o); // R7
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked) |=> !irq_o); // R7
    AST_ID_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_id_vld_o |-> masked[irq_id_o[ID_W-2:0]]); // R8
    AST_ID_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_id_vld_o |-> (irq_id_o == ID_W'(NSRC) && masked == '0)); // R8
    AST_RAW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_RAW) |=> ((pend & $past(pend)) == $past(pend))); // R9
endmodule

// File: tb/irq_setclr_ctrl_test.sv
module irq_setclr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [5:0]  id;
    logic        vld;
    int          ntests = 0;
    int          nfail = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    irq_setclr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .irq_id_o(id), .irq_id_vld_o(vld)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2 d = rdata;
        rd = 1'b0;
    endtask

    task automatic drive_src(input logic [31:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    task automatic t_reset;
        bus_read(2'd1, v); chk("R1", "raw after reset", v, 32'h0);
        bus_read(2'd0, v); chk("R1", "masked after reset", v, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
        chk("R1", "id after reset", {26'b0, id}, 32'd32);
        chk("R1", "vld after reset", {31'b0, vld}, 32'h0);
    endtask

    task automatic t_edge_and_lag;
        bus_write(2'd2, 32'hFFFF_FFFF);
        drive_src(32'h0000_0020);
        chk("R7", "irq one cycle after pending", {31'b0, irq}, 32'h0);
        bus_read(2'd1, v); chk("R2", "edge latched bit5", v, 32'h0000_0020);
        chk("R7", "irq two cycles after edge", {31'b0, irq}, 32'h1);
        chk("R8", "id of source 5", {26'b0, id}, 32'd5);
        drive_src(32'h0);
        bus_read(2'd1, v); chk("R2", "bit5 sticky after line low", v, 32'h0000_0020);
        bus_write(2'd0, 32'h0000_0020);
        bus_read(2'd1, v); chk("R5", "bit5 acknowledged", v, 32'h0);
        @(negedge clk);
        chk("R7", "irq low after ack", {31'b0, irq}, 32'h0);
        drive_src(32'h0000_0080);
        bus_write(2'd0, 32'h0000_0080);
        drive_src(32'h0000_0080);
        bus_read(2'd1, v); chk("R2", "held-high line no relatch", v, 32'h0);
        drive_src(32'h0);
    endtask

    task automatic t_enables;
        bus_write(2'd3, 32'hFFFF_FFFF);
        drive_src(32'h0000_0208);
        bus_read(2'd1, v); chk("R6", "raw shows disabled pending", v, 32'h0000_0208);
        bus_read(2'd0, v); chk("R4", "masked zero after all-clear", v, 32'h0);
        chk("R8", "no valid id when masked", {26'b0, id, vld}, {25'b0, 6'd32, 1'b0});
        chk("R7", "irq low when all disabled", {31'b0, irq}, 32'h0);
        bus_write(2'd2, 32'h0000_0200);
        bus_read(2'd0, v); chk("R3", "enable bit9 set", v, 32'h0000_0200);
        chk("R8", "id 9", {26'b0, id}, 32'd9);
        bus_write(2'd2, 32'h0000_0008);
        bus_read(2'd0, v); chk("R3", "zeros keep bit9 enabled", v, 32'h0000_0208);
        chk("R8", "id 3 lowest", {26'b0, id}, 32'd3);
        bus_write(2'd3, 32'h0000_0008);
        bus_read(2'd0, v); chk("R4", "bit3 cleared only", v, 32'h0000_0200);
        drive_src(32'h0);
    endtask

    task automatic t_ignored;
        bus_write(2'd0, 32'h0000_0200);
        bus_read(2'd1, v); chk("R5", "partial ack keeps bit3", v, 32'h0000_0008);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, v); chk("R9", "write to raw ignored", v, 32'h0000_0008);
        bus_read(2'd2, v); chk("R9", "enable-set reads zero", v, 32'h0);
        bus_read(2'd3, v); chk("R9", "enable-clear reads zero", v, 32'h0);
        bus_write(2'd0, 32'h0000_0008);
    endtask

    task automatic t_ack_race;
        @(negedge clk);
        addr = 2'd0; wdata = 32'h0000_1000; wr = 1'b1; src = 32'h0000_1000;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        bus_read(2'd1, v); chk("R5", "edge wins over same-cycle ack", v, 32'h0000_1000);
        drive_src(32'h0);
        bus_write(2'd0, 32'h0000_1000);
    endtask

    task automatic t_priority;
        bus_write(2'd2, 32'hFFFF_FFFF);
        drive_src(32'h8000_0001);
        chk("R8", "id 0 over 31", {26'b0, id, vld}, {25'b0, 6'd0, 1'b1});
        bus_write(2'd0, 32'h0000_0001);
        chk("R8", "id 31 after ack 0", {26'b0, id, vld}, {25'b0, 6'd31, 1'b1});
        bus_write(2'd0, 32'h8000_0000);
        chk("R8", "none code after ack 31", {26'b0, id, vld}, {25'b0, 6'd32, 1'b0});
        drive_src(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge_and_lag();
        t_enables();
        t_ignored();
        t_ack_race();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        #4000000;
        ntests++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule